// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Staged Commit

This block derives a divided clock-enable pulse train from one of several source tick streams. The divide ratio is a fixed-point number. A divisor field of `DIV_W` bits holding value N, with `FRAC_W` fractional bits, divides the selected source by (N + 2^FRAC_W) / 2^FRAC_W. A field of zero passes every source tick through. A phase accumulator spreads the fractional part over successive output periods.

Software talks to the block through one 32-bit control word. It writes a divisor and a source selector into staged fields, with a per-bit write mask. Neither field affects the running divider until software writes 1 to the commit bit. The commit bit then reads as busy. At the next output pulse the divider loads both staged values and restarts its accumulator from zero, and the busy bit clears by itself. A run bit enables the divided output. It must be set for a commit to be accepted, because the switch-over happens on an output pulse.

Top module: `frac_clk_div`

## Requirements
- R1: With the run bit set, ticks present on every cycle and an active divisor field N, the block emits exactly floor(t * 2^FRAC_W / (N + 2^FRAC_W)) pulses in the t ticks that follow a commit. `div_pulse` is registered and appears one cycle after the tick that produces it.
- R2: An active divisor field of 0 yields one output pulse for every selected source tick.
- R3: An all-ones divisor field gives the largest ratio, (2^DIV_W - 1 + 2^FRAC_W) / 2^FRAC_W. With the defaults this is 8 pulses in 263 ticks.
- R4: The control word layout is: staged divisor at bits [DIV_SHIFT +: DIV_W] (default [11:4]), staged selector at bits [SEL_SHIFT +: SEL_W] (default [17:16]), run bit at GATE_BIT (default 0), and commit/busy bit at TRIG_BIT (default 31). A write changes only the bits whose `bus_wmask` bit is 1. Every other bit reads as 0.
- R5: Staged divisor and selector values have no effect on `div_pulse`, `act_div` or `act_sel` until a commit completes.
- R6: Writing 1 to the commit bit while the run bit is set and no commit is pending makes the busy bit read 1 for at least the two cycles after the write. The bit then clears on its own once the new values are in use.
- R7: A commit takes effect on an output pulse. At that pulse `act_div` and `act_sel` take the staged values and the accumulator restarts from zero.
- R8: The active selector value s picks `src_tick[s]`. Ticks on the other sources produce no output.
- R9: While the run bit is clear, `div_pulse` stays 0 and the accumulator is held at zero. A commit request written while the run bit is clear is ignored, and the busy bit stays 0.
- R10: After reset the control word reads 0, and `act_div`, `act_sel` and `div_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Control word write strobe |
| bus_wmask | input | 32 | Per-bit write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current control word contents |
| src_tick | input | NUM_SRC | One tick enable per source |
| div_pulse | output | 1 | Divided clock-enable pulse |
| act_div | output | DIV_W | Divisor field in use |
| act_sel | output | SEL_W | Selector value in use |

## Verification
The bench uses the default parameters: an 8-bit divisor with 3 fractional bits and four sources. This keeps the largest ratio, about 32.9, within a few hundred cycles, so the extreme field value and fractional carry patterns are reached in short directed runs. Under random masked writes and random tick patterns, a cycle-level reference compares every output every cycle. Directed counts check pulse totals against the closed-form floor formula.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  // Mask of `width` ones starting at bit `shift` of a 32-bit word.
  function automatic logic [31:0] fld_mask(input int unsigned shift, input int unsigned width);
    fld_mask = ((32'd1 << width) - 32'd1) << shift;
  endfunction
endpackage

// File: rtl/frac_div_srcsel.sv
module frac_div_srcsel #(
  parameter int SEL_W   = 2,
  parameter int NUM_SRC = 4
) (
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   sel,
  output logic               tick
);
  logic [NUM_SRC-1:0] hit;
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = src_tick[g] && (sel == SEL_W'(g));
  end
  assign tick = |hit;
endmodule

// File: rtl/frac_div_regs.sv
module frac_div_regs #(
  parameter int DIV_W     = 8,
  parameter int SEL_W     = 2,
  parameter int DIV_SHIFT = 4,
  parameter int SEL_SHIFT = 16,
  parameter int GATE_BIT  = 0,
  parameter int TRIG_BIT  = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wmask,
  input  logic [31:0]      bus_wdata,
  input  logic             boundary,
  output logic             commit,
  output logic [DIV_W-1:0] pend_div,
  output logic [SEL_W-1:0] pend_sel,
  output logic             gate,
  output logic             busy
);
  logic [DIV_W-1:0] dmask, dval;
  logic [SEL_W-1:0] smask, sval;
  logic             trig_req, accept, armed_q;
  logic             unused_bus;

  assign dmask    = bus_wmask[DIV_SHIFT +: DIV_W];
  assign dval     = bus_wdata[DIV_SHIFT +: DIV_W];
  assign smask    = bus_wmask[SEL_SHIFT +: SEL_W];
  assign sval     = bus_wdata[SEL_SHIFT +: SEL_W];
  assign trig_req = bus_wr && bus_wmask[TRIG_BIT] && bus_wdata[TRIG_BIT];
  assign accept   = trig_req && gate && !busy;
  // Switch-over only once the request has aged one cycle, and only on a pulse.
  assign commit   = busy && armed_q && boundary;
  assign unused_bus = ^{bus_wmask, bus_wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_div <= '0;
      pend_sel <= '0;
      gate     <= 1'b0;
      busy     <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      if (bus_wr) begin
        pend_div <= (pend_div & ~dmask) | (dval & dmask);
        pend_sel <= (pend_sel & ~smask) | (sval & smask);
        if (bus_wmask[GATE_BIT]) gate <= bus_wdata[GATE_BIT];
      end
      if (accept) begin
        busy    <= 1'b1;
        armed_q <= 1'b0;
      end else if (commit) begin
        busy    <= 1'b0;
        armed_q <= 1'b0;
      end else begin
        armed_q <= busy;
      end
    end
  end

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy); // R6
  AST_TRIG_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    (trig_req && !gate && !busy) |=> !busy); // R9
endmodule

// File: rtl/frac_div_core.sv
module frac_div_core #(
  parameter int DIV_W  = 8,
  parameter int FRAC_W = 3,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate,
  input  logic             tick,
  input  logic             commit,
  input  logic [DIV_W-1:0] pend_div,
  input  logic [SEL_W-1:0] pend_sel,
  output logic             boundary,
  output logic [DIV_W-1:0] act_div,
  output logic [SEL_W-1:0] act_sel,
  output logic             pulse
);
  localparam int ACC_W = DIV_W + 2;
  localparam logic [ACC_W-1:0] ONE_EXT = ACC_W'(1) << FRAC_W;

  logic [ACC_W-1:0] acc_q, n_ext;

  assign n_ext = ACC_W'(act_div);
  // acc + 2^F >= N + 2^F reduces to acc >= N
  assign boundary = gate && tick && (acc_q >= n_ext);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      act_div <= '0;
      act_sel <= '0;
      pulse   <= 1'b0;
    end else if (!gate) begin
      acc_q <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= boundary;
      if (commit) begin
        acc_q   <= '0;
        act_div <= pend_div;
        act_sel <= pend_sel;
      end else if (tick) begin
        acc_q <= boundary ? (acc_q - n_ext) : (acc_q + ONE_EXT);
      end
    end
  end

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(act_div)); // R5
  AST_RUN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !gate |=> !pulse); // R9
  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (rst)
    acc_q < (n_ext + ONE_EXT)); // R1
  AST_PULSE_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(tick)); // R8
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int DIV_W     = 8,
  parameter int FRAC_W    = 3,
  parameter int SEL_W     = 2,
  parameter int DIV_SHIFT = 4,
  parameter int SEL_SHIFT = 16,
  parameter int GATE_BIT  = 0,
  parameter int TRIG_BIT  = 31,
  localparam int NUM_SRC  = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wmask,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic               div_pulse,
  output logic [DIV_W-1:0]   act_div,
  output logic [SEL_W-1:0]   act_sel
);
  import frac_div_pkg::*;

  logic             commit, boundary, gate, busy, tick;
  logic [DIV_W-1:0] pend_div;
  logic [SEL_W-1:0] pend_sel;

  frac_div_regs #(
    .DIV_W(DIV_W), .SEL_W(SEL_W), .DIV_SHIFT(DIV_SHIFT),
    .SEL_SHIFT(SEL_SHIFT), .GATE_BIT(GATE_BIT), .TRIG_BIT(TRIG_BIT)
  ) i_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wmask(bus_wmask),
    .bus_wdata(bus_wdata), .boundary(boundary), .commit(commit),
    .pend_div(pend_div), .pend_sel(pend_sel), .gate(gate), .busy(busy)
  );

  frac_div_srcsel #(.SEL_W(SEL_W), .NUM_SRC(NUM_SRC)) i_srcsel (
    .src_tick(src_tick), .sel(act_sel), .tick(tick)
  );

  frac_div_core #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .SEL_W(SEL_W)) i_core (
    .clk(clk), .rst(rst), .gate(gate), .tick(tick), .commit(commit),
    .pend_div(pend_div), .pend_sel(pend_sel), .boundary(boundary),
    .act_div(act_div), .act_sel(act_sel), .pulse(div_pulse)
  );

  always_comb begin
    bus_rdata = '0;
    bus_rdata[DIV_SHIFT +: DIV_W] = pend_div;
    bus_rdata[SEL_SHIFT +: SEL_W] = pend_sel;
    bus_rdata[GATE_BIT] = gate;
    bus_rdata[TRIG_BIT] = busy;
  end

  AST_MAP_DISJOINT: assert property (@(posedge clk)
    (fld_mask(DIV_SHIFT, DIV_W) & fld_mask(SEL_SHIFT, SEL_W)) == 32'd0); // R4
endmodule

// File: tb/test_frac_clk_div.sv
module test_frac_clk_div;
  import frac_div_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8, FRAC_W = 3, SEL_W = 2;
  localparam int DIV_SHIFT = 4, SEL_SHIFT = 16, GATE_BIT = 0, TRIG_BIT = 31;
  localparam int NUM_SRC = 1 << SEL_W;
  localparam logic [31:0] DMSK = fld_mask(DIV_SHIFT, DIV_W);
  localparam logic [31:0] SMSK = fld_mask(SEL_SHIFT, SEL_W);
  localparam logic [31:0] GMSK = 32'd1 << GATE_BIT;
  localparam logic [31:0] TMSK = 32'd1 << TRIG_BIT;

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0;
  logic [31:0] bus_wmask = '0, bus_wdata = '0, bus_rdata;
  logic [NUM_SRC-1:0] src_tick = '0;
  logic div_pulse;
  logic [DIV_W-1:0] act_div;
  logic [SEL_W-1:0] act_sel;
  int checks = 0, fails = 0;
  bit done = 0;

  frac_clk_div #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .SEL_W(SEL_W), .DIV_SHIFT(DIV_SHIFT),
    .SEL_SHIFT(SEL_SHIFT), .GATE_BIT(GATE_BIT), .TRIG_BIT(TRIG_BIT)) i_frac_clk_div (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wmask(bus_wmask), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_tick(src_tick), .div_pulse(div_pulse),
    .act_div(act_div), .act_sel(act_sel));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model built from the requirements
  int m_pdiv, m_psel, m_adiv, m_asel, m_acc;
  bit m_gate, m_busy, m_armed, m_pulse, m_bnd, m_commit, m_tick;
  always @(posedge clk) begin
    if (rst) begin
      m_pdiv = 0; m_psel = 0; m_adiv = 0; m_asel = 0; m_acc = 0;
      m_gate = 0; m_busy = 0; m_armed = 0; m_pulse = 0;
    end else begin
      m_tick   = src_tick[m_asel];
      m_bnd    = m_gate && m_tick && (m_acc >= m_adiv);
      m_commit = m_busy && m_armed && m_bnd;
      if (!m_gate) begin m_acc = 0; m_pulse = 0; end
      else begin
        m_pulse = m_bnd;
        if (m_commit) begin m_acc = 0; m_adiv = m_pdiv; m_asel = m_psel; end
        else if (m_tick) m_acc = m_bnd ? m_acc - m_adiv : m_acc + (1 << FRAC_W);
      end
      if (bus_wr && bus_wmask[TRIG_BIT] && bus_wdata[TRIG_BIT] && m_gate && !m_busy) begin
        m_busy = 1; m_armed = 0;
      end else if (m_commit) begin m_busy = 0; m_armed = 0; end
      else m_armed = m_busy;
      if (bus_wr) begin
        m_pdiv = int'(((32'(m_pdiv) << DIV_SHIFT) & ~bus_wmask | bus_wdata & bus_wmask & DMSK) >> DIV_SHIFT) & ((1 << DIV_W) - 1);
        m_psel = int'(((32'(m_psel) << SEL_SHIFT) & ~bus_wmask | bus_wdata & bus_wmask & SMSK) >> SEL_SHIFT) & ((1 << SEL_W) - 1);
        if (bus_wmask[GATE_BIT]) m_gate = bus_wdata[GATE_BIT];
      end
    end
  end

  function automatic logic [31:0] exp_word();
    return (32'(m_pdiv) << DIV_SHIFT) | (32'(m_psel) << SEL_SHIFT) |
           (32'(m_gate) << GATE_BIT) | (32'(m_busy) << TRIG_BIT);
  endfunction

  function automatic int exp_pulses(int n, int t);
    return (t << FRAC_W) / (n + (1 << FRAC_W));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock, then compare every output against the model.
  task automatic cyc();
    @(posedge clk); @(negedge clk);
    chk("R1 pulse", 32'(div_pulse), 32'(m_pulse));
    chk("R4 rdata", bus_rdata, exp_word());
    chk("R5 act_div", 32'(act_div), 32'(m_adiv));
    chk("R8 act_sel", 32'(act_sel), 32'(m_asel));
  endtask

  task automatic wr(logic [31:0] mask, logic [31:0] data);
    bus_wr = 1; bus_wmask = mask; bus_wdata = data;
    cyc();
    bus_wr = 0; bus_wmask = '0; bus_wdata = '0;
  endtask

  task automatic do_commit(int n, int s);
    src_tick = '1;
    wr(DMSK | SMSK, (32'(n) << DIV_SHIFT) | (32'(s) << SEL_SHIFT));
    wr(TMSK, TMSK);
    chk("R6 busy first", 32'(bus_rdata[TRIG_BIT]), 1);
    cyc();
    chk("R6 busy second", 32'(bus_rdata[TRIG_BIT]), 1);
    for (int i = 0; i < 600 && bus_rdata[TRIG_BIT]; i++) cyc();
    chk("R6 busy clears", 32'(bus_rdata[TRIG_BIT]), 0);
    chk("R7 act_div loaded", 32'(act_div), 32'(n));
    chk("R7 act_sel loaded", 32'(act_sel), 32'(s));
  endtask

  task automatic count(int t, logic [NUM_SRC-1:0] tm, output int p);
    p = 0; src_tick = tm;
    for (int i = 0; i < t; i++) begin cyc(); if (div_pulse) p++; end
  endtask

  initial begin
    int p;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    cyc();
    chk("R10 rdata", bus_rdata, 0);
    chk("R10 act_div", 32'(act_div), 0);
    chk("R10 pulse", 32'(div_pulse), 0);
    wr(GMSK, GMSK);
    do_commit(0, 0);
    count(16, '1, p); chk("R2 every tick", p, 16);
    do_commit(4, 0);
    count(12, '1, p); chk("R1 ratio 1.5", p, exp_pulses(4, 12));
    do_commit(255, 0);
    count(263, '1, p); chk("R3 max ratio", p, exp_pulses(255, 263));
    wr(DMSK, 0);
    count(10, '1, p); chk("R5 staged no effect", p, 0);
    chk("R5 act_div kept", 32'(act_div), 255);
    wr(SMSK, 32'd3 << SEL_SHIFT);
    chk("R4 div untouched", (bus_rdata & DMSK) >> DIV_SHIFT, 0);
    chk("R4 sel written", (bus_rdata & SMSK) >> SEL_SHIFT, 3);
    wr(~TMSK, '1);
    chk("R4 spare bits zero", bus_rdata & ~(DMSK | SMSK | GMSK | TMSK), 0);
    do_commit(0, 2);
    count(10, 4'b0010, p); chk("R8 other source", p, 0);
    count(10, 4'b0100, p); chk("R8 chosen source", p, 10);
    wr(GMSK, 0);
    count(10, '1, p); chk("R9 stopped", p, 0);
    wr(TMSK, TMSK);
    chk("R9 trigger ignored", 32'(bus_rdata[TRIG_BIT]), 0);
    wr(GMSK, GMSK);
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] m, d;
      src_tick = NUM_SRC'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        case ($urandom_range(0, 3))
          0: m = DMSK; 1: m = SMSK; 2: m = TMSK; default: m = $urandom;
        endcase
        d = $urandom;
        d[GATE_BIT] = ($urandom_range(0, 7) != 0);
        bus_wr = 1; bus_wmask = m; bus_wdata = d;
      end
      cyc();
      bus_wr = 0; bus_wmask = '0; bus_wdata = '0;
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule